// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a host-side configuration requester and a plain memory-mapped master port. Each request names a bus number, a device number, a function number, a byte offset into configuration space, an access size of 1, 2 or 4 bytes, and write data for writes. The block turns the request into one or two aligned 32-bit accesses. Accesses to bus 0 land in a local register window. Accesses to higher buses land in a remote configuration window, and the bus number is rebased by one before it goes into the address.

Targets that cannot exist are rejected without touching the master port. Sub-word reads are taken from the returned word by shifting out the addressed byte lane. Sub-word writes are carried out as a read of the word, a merge of the new lanes, and a write-back to the same address. Only one request is in flight at a time. A busy output tells the requester when a new request will be taken.

Top module: `cfg_xlate`

## Requirements
- R1: A bus 0 access uses address LOCAL_BASE + (offset with bits 1:0 cleared), so an unaligned offset such as 0x13 maps to LOCAL_BASE + 0x10.
- R2: An access to a bus from 1 to MAX_BUS uses address REMOTE_BASE + (((bus-1) & 0xFF) << 16) + (device << 11) + (function << 8) + (offset with bits 1:0 cleared).
- R3: A request is rejected with status NOT_FOUND (code 1) and makes no master access when its bus is above MAX_BUS (default 1) or its device or function is nonzero. A rejected read returns 0xFFFFFFFF and a rejected write returns 0.
- R4: A size other than 1, 2 or 4 on an accepted target gives status BAD_REG (code 2), returns 0 and makes no master access. When the target is also invalid, NOT_FOUND takes precedence.
- R5: A 4-byte read returns the whole word. A 1-byte read returns (word >> 8*(offset & 3)) & 0xFF, and a 2-byte read returns (word >> 8*(offset & 3)) & 0xFFFF.
- R6: A 1-byte or 2-byte write performs a read followed by a write to the same address. The written word keeps every byte outside the target lanes and replaces the target lanes with the low 8 or 16 bits of the write data, shifted left by 8*(offset & 3). Lanes that would fall past byte 3 are dropped.
- R7: A 4-byte write performs exactly one master write of the write data and no read.
- R8: busy rises on the clock edge that accepts a request and stays high until the edge that raises the response. A request presented while busy is high is ignored and produces no access and no response.
- R9: A master request holds m_req, m_we, m_addr and m_wdata steady until the cycle m_ack is sampled high, and every master address is 4-byte aligned.
- R10: rsp_valid is a single-cycle pulse carrying status OK (code 0), NOT_FOUND (code 1) or BAD_REG (code 2). A successful write returns data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | OFF_W | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 OK, 1 NOT_FOUND, 2 BAD_REG |
| rsp_rdata | output | 32 | Read result, lane-extracted |
| m_req | output | 1 | Master access request |
| m_we | output | 1 | Master write enable |
| m_addr | output | AW | Master word address |
| m_wdata | output | 32 | Master write data |
| m_ack | input | 1 | Access accepted; read data valid |
| m_rdata | input | 32 | Master read data |

## Verification
Assertions check the port protocol on every cycle. While waiting for m_ack the master request stays steady and aligned. Every master request happens with busy high. The response is a one-cycle pulse that lands only after busy has dropped and no access is outstanding. The write-back of a read-modify-write reuses the address of its read. The address arithmetic for each window, the lane extraction and merge values, rejection with its precedence, and ignoring requests while busy can only be shown by the bench scenarios. The bench's behavioural model predicts every access and response, and it varies the acknowledge latency.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int SIZE_W = 3;
  localparam int DW     = 32;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NOTFOUND = 2'd1,
    ST_BADREG   = 2'd2
  } cfg_status_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_READ,
    SQ_WRITE,
    SQ_RESP
  } seq_state_e;

  function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/cfg_xlate_addr.sv
module cfg_xlate_addr
  import cfg_xlate_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          OFF_W       = 12,
  parameter int          MAX_BUS     = 1,
  parameter logic [AW-1:0] LOCAL_BASE  = 32'h4000_0000,
  parameter logic [AW-1:0] REMOTE_BASE = 32'h5000_0000
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [OFF_W-1:0]  off,
  output logic [AW-1:0]     addr,
  output logic              target_ok
);
  localparam int BUS_SH  = 16;
  localparam int DEV_SH  = 11;
  localparam int FUNC_SH = 8;

  logic [OFF_W-1:0] aligned_off;
  logic [BUS_W-1:0] rebased_bus;
  logic [AW-1:0]    local_addr;
  logic [AW-1:0]    remote_addr;

  assign aligned_off = {off[OFF_W-1:2], 2'b00};
  assign rebased_bus = bus - BUS_W'(1);

  assign local_addr  = LOCAL_BASE + AW'(aligned_off);
  assign remote_addr = REMOTE_BASE
                     + (AW'(rebased_bus) << BUS_SH)
                     + (AW'(dev)         << DEV_SH)
                     + (AW'(func)        << FUNC_SH)
                     + AW'(aligned_off);

  assign addr      = (bus == '0) ? local_addr : remote_addr;
  assign target_ok = (bus <= BUS_W'(MAX_BUS)) && (dev == '0) && (func == '0);
endmodule

// File: rtl/cfg_xlate_lane.sv
module cfg_xlate_lane
  import cfg_xlate_pkg::*;
#(
  parameter int LANES  = DW / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [DW-1:0]     word,
  input  logic [LANE_W-1:0] lane,
  input  logic [SIZE_W-1:0] size,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_val,
  output logic [DW-1:0]     merged
);
  localparam int SH_W = LANE_W + 3;

  logic [SH_W-1:0]  shift;
  logic [DW-1:0]    keep_mask;
  logic [DW-1:0]    wd_shifted;
  logic [LANES-1:0] byte_en;

  assign shift      = {lane, 3'b000};
  assign keep_mask  = (size == 3'd1) ? DW'(8'hFF) : DW'(16'hFFFF);
  assign rd_val     = (word >> shift) & keep_mask;
  assign wd_shifted = (wdata & keep_mask) << shift;
  assign byte_en    = (size == 3'd1) ? (LANES'(1) << lane) : (LANES'(3) << lane);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = byte_en[g] ? wd_shifted[g*8 +: 8] : word[g*8 +: 8];
  end
endmodule

// File: rtl/cfg_xlate_seq.sv
module cfg_xlate_seq
  import cfg_xlate_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [LANE_W-1:0] req_lane,
  input  logic [DW-1:0]     req_wdata,
  input  logic [AW-1:0]     xl_addr,
  input  logic              xl_ok,
  input  logic [DW-1:0]     ln_rd_val,
  input  logic [DW-1:0]     ln_merged,
  output logic              held_write,
  output logic [SIZE_W-1:0] held_size,
  output logic [LANE_W-1:0] held_lane,
  output logic [DW-1:0]     held_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DW-1:0]     rsp_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ack,
  input  logic [DW-1:0]     m_rdata
);
  seq_state_e  state;
  cfg_status_e pend_status;
  logic [DW-1:0] pend_data;
  logic          full_write;

  assign full_write = req_write && (req_size == 3'd4);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      busy        <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_status  <= ST_OK;
      rsp_rdata   <= '0;
      m_req       <= 1'b0;
      m_we        <= 1'b0;
      m_addr      <= '0;
      m_wdata     <= '0;
      pend_status <= ST_OK;
      pend_data   <= '0;
      held_write  <= 1'b0;
      held_size   <= '0;
      held_lane   <= '0;
      held_wdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            busy       <= 1'b1;
            held_write <= req_write;
            held_size  <= req_size;
            held_lane  <= req_lane;
            held_wdata <= req_wdata;
            if (!xl_ok) begin
              pend_status <= ST_NOTFOUND;
              pend_data   <= req_write ? '0 : '1;
              state       <= SQ_RESP;
            end else if (!size_legal(req_size)) begin
              pend_status <= ST_BADREG;
              pend_data   <= '0;
              state       <= SQ_RESP;
            end else begin
              m_req   <= 1'b1;
              m_we    <= full_write;
              m_addr  <= xl_addr;
              m_wdata <= req_wdata;
              state   <= full_write ? SQ_WRITE : SQ_READ;
            end
          end
        end
        SQ_READ: begin
          if (m_ack) begin
            if (held_write) begin
              m_we    <= 1'b1;
              m_wdata <= ln_merged;
              state   <= SQ_WRITE;
            end else begin
              m_req      <= 1'b0;
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
              rsp_rdata  <= (held_size == 3'd4) ? m_rdata : ln_rd_val;
              busy       <= 1'b0;
              state      <= SQ_IDLE;
            end
          end
        end
        SQ_WRITE: begin
          if (m_ack) begin
            m_req      <= 1'b0;
            m_we       <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_rdata  <= '0;
            busy       <= 1'b0;
            state      <= SQ_IDLE;
          end
        end
        default: begin
          rsp_valid  <= 1'b1;
          rsp_status <= pend_status;
          rsp_rdata  <= pend_data;
          busy       <= 1'b0;
          state      <= SQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int            AW          = 32,
  parameter int            OFF_W       = 12,
  parameter int            MAX_BUS     = 1,
  parameter logic [AW-1:0] LOCAL_BASE  = 32'h4000_0000,
  parameter logic [AW-1:0] REMOTE_BASE = 32'h5000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_dev,
  input  logic [2:0]        req_func,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [31:0]       rsp_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [31:0]       m_wdata,
  input  logic              m_ack,
  input  logic [31:0]       m_rdata
);
  localparam int LANES  = DW / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [AW-1:0]     xl_addr;
  logic              xl_ok;
  logic              held_write;
  logic [SIZE_W-1:0] held_size;
  logic [LANE_W-1:0] held_lane;
  logic [DW-1:0]     held_wdata;
  logic [DW-1:0]     ln_rd_val;
  logic [DW-1:0]     ln_merged;

  cfg_xlate_addr #(
    .AW(AW), .OFF_W(OFF_W), .MAX_BUS(MAX_BUS),
    .LOCAL_BASE(LOCAL_BASE), .REMOTE_BASE(REMOTE_BASE)
  ) i_addr (
    .bus(req_bus), .dev(req_dev), .func(req_func), .off(req_off),
    .addr(xl_addr), .target_ok(xl_ok)
  );

  cfg_xlate_lane #(.LANES(LANES), .LANE_W(LANE_W)) i_lane (
    .word(m_rdata), .lane(held_lane), .size(held_size), .wdata(held_wdata),
    .rd_val(ln_rd_val), .merged(ln_merged)
  );

  cfg_xlate_seq #(.AW(AW), .LANE_W(LANE_W)) i_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_lane(req_off[LANE_W-1:0]), .req_wdata(req_wdata),
    .xl_addr(xl_addr), .xl_ok(xl_ok),
    .ln_rd_val(ln_rd_val), .ln_merged(ln_merged),
    .held_write(held_write), .held_size(held_size),
    .held_lane(held_lane), .held_wdata(held_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_rdata(m_rdata)
  );
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          rsp_valid,
  input logic          m_req,
  input logic          m_we,
  input logic          m_ack,
  input logic [AW-1:0] m_addr,
  input logic [31:0]   m_wdata
);
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata)));

  // R9
  aligned_addr_chk: assert property (@(posedge clk) disable iff (rst)
    m_req |-> (m_addr[1:0] == 2'b00));

  // R8
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    m_req |-> busy);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!busy && !m_req));

  // R6
  rmw_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_we && m_ack) |=> (!m_req || (m_addr == $past(m_addr))));
endmodule

bind cfg_xlate cfg_xlate_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .m_req(m_req), .m_we(m_we), .m_ack(m_ack),
  .m_addr(m_addr), .m_wdata(m_wdata)
);

// File: tb/test_cfg_xlate.sv
module test_cfg_xlate;
  localparam logic [31:0] LB = 32'h4000_0000;
  localparam logic [31:0] RB = 32'h5000_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [11:0] req_off = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, rsp_valid, m_req, m_we;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata, m_addr, m_wdata;
  logic        m_ack = 1'b0;
  logic [31:0] m_rdata = '0;

  cfg_xlate #(.LOCAL_BASE(LB), .REMOTE_BASE(RB)) i_cfg_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
  );

  typedef struct { int tag; logic we; logic [31:0] addr; logic [31:0] data; } acc_t;
  typedef struct { int tag; logic [1:0] st; logic [31:0] data; } rsp_t;

  int total = 0, bad = 0;
  int lat = 0, wcnt = 0;
  logic exp_busy = 1'b0;
  logic [31:0] mem [logic [31:0]];
  acc_t exp_acc[$];
  rsp_t exp_rsp[$];
  acc_t ea;
  rsp_t er;

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_1234);
  endfunction

  task automatic chk(int tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory responder and per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (m_ack) begin
        m_ack = 1'b0;
      end else if (m_req) begin
        if (wcnt >= lat) begin
          wcnt = 0;
          if (exp_acc.size() == 0) begin
            chk(9, "unexpected access addr", m_addr, 32'hxxxx_xxxx);
          end else begin
            ea = exp_acc.pop_front();
            chk(ea.tag, "access direction", {31'b0, m_we}, {31'b0, ea.we});
            chk(ea.tag, "access address", m_addr, ea.addr);
            if (ea.we) chk(ea.tag, "access write data", m_wdata, ea.data);
          end
          if (m_we) mem[m_addr] = m_wdata;
          else m_rdata = mrd(m_addr);
          m_ack = 1'b1;
        end else begin
          wcnt++;
        end
      end
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) begin
          chk(8, "unexpected response", {30'b0, rsp_status}, 32'hxxxx_xxxx);
        end else begin
          er = exp_rsp.pop_front();
          chk(er.tag, "status", {30'b0, rsp_status}, {30'b0, er.st});
          chk(er.tag, "response data", rsp_rdata, er.data);
        end
        chk(8, "busy low at response", {31'b0, busy}, 32'd0);
        exp_busy = 1'b0;
      end else if (exp_busy) begin
        chk(8, "busy held", {31'b0, busy}, 32'd1);
      end
    end
  end

  task automatic do_req(int tag, logic wr, logic [7:0] bus, logic [4:0] dev,
                        logic [2:0] fn, logic [11:0] off, logic [2:0] sz,
                        logic [31:0] wd, bit poke);
    logic [31:0] a, w, msk, dsh;
    logic ok, szok;
    int sh;
    a = (bus == 0) ? LB + {20'b0, off[11:2], 2'b00}
                   : RB + ({24'b0, 8'(bus - 8'd1)} << 16) + ({27'b0, dev} << 11)
                        + ({29'b0, fn} << 8) + {20'b0, off[11:2], 2'b00};
    ok   = (bus <= 8'd1) && (dev == 0) && (fn == 0);
    szok = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    sh   = 8 * int'(off[1:0]);
    msk  = (sz == 3'd1) ? 32'hFF : 32'hFFFF;
    w    = mrd(a);
    if (!ok) begin
      exp_rsp.push_back('{tag, 2'd1, wr ? 32'h0 : 32'hFFFF_FFFF});
    end else if (!szok) begin
      exp_rsp.push_back('{tag, 2'd2, 32'h0});
    end else if (wr && sz == 3'd4) begin
      exp_acc.push_back('{tag, 1'b1, a, wd});
      exp_rsp.push_back('{tag, 2'd0, 32'h0});
    end else if (wr) begin
      dsh = (wd & msk) << sh;
      exp_acc.push_back('{tag, 1'b0, a, 32'h0});
      exp_acc.push_back('{tag, 1'b1, a, (w & ~(msk << sh)) | dsh});
      exp_rsp.push_back('{tag, 2'd0, 32'h0});
    end else begin
      exp_acc.push_back('{tag, 1'b0, a, 32'h0});
      exp_rsp.push_back('{tag, 2'd0, (sz == 3'd4) ? w : ((w >> sh) & msk)});
    end
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
    req_func = fn; req_off = off; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    exp_busy  = 1'b1;
    if (poke) begin
      req_valid = 1'b1; req_write = 1'b1; req_bus = 8'd0; req_dev = '0;
      req_func = '0; req_off = 12'h040; req_size = 3'd4; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (exp_rsp.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 R9 R10: idle after reset
    chk(8,  "reset busy",  {31'b0, busy}, 32'd0);
    chk(10, "reset rsp",   {31'b0, rsp_valid}, 32'd0);
    chk(9,  "reset m_req", {31'b0, m_req}, 32'd0);

    for (int l = 0; l < 4; l++) begin
      lat = l;
      // R1 R5: local whole-word reads, aligned and unaligned
      do_req(1, 1'b0, 8'd0, 5'd0, 3'd0, 12'h010, 3'd4, 0, 1'b0);
      do_req(1, 1'b0, 8'd0, 5'd0, 3'd0, 12'h013, 3'd4, 0, 1'b0);
      // R2: remote window read
      do_req(2, 1'b0, 8'd1, 5'd0, 3'd0, 12'h024, 3'd4, 0, 1'b0);
      // R5: byte reads on every lane, halfword reads
      for (int b = 0; b < 4; b++)
        do_req(5, 1'b0, 8'd0, 5'd0, 3'd0, 12'h100 + 12'(b), 3'd1, 0, 1'b0);
      do_req(5, 1'b0, 8'd1, 5'd0, 3'd0, 12'h102, 3'd2, 0, 1'b0);
      do_req(5, 1'b0, 8'd1, 5'd0, 3'd0, 12'h103, 3'd2, 0, 1'b0);
      // R7: full write then read back
      do_req(7, 1'b1, 8'd0, 5'd0, 3'd0, 12'h080 + 12'(4*l), 3'd4, 32'h1122_3344 + l, 1'b0);
      do_req(7, 1'b0, 8'd0, 5'd0, 3'd0, 12'h080 + 12'(4*l), 3'd4, 0, 1'b0);
      // R6: byte and halfword read-modify-write, including past-the-word lane
      do_req(6, 1'b1, 8'd1, 5'd0, 3'd0, 12'h0C1, 3'd1, 32'hFFFF_FFA5, 1'b0);
      do_req(6, 1'b1, 8'd1, 5'd0, 3'd0, 12'h0C2, 3'd2, 32'h0000_BEEF, 1'b0);
      do_req(6, 1'b1, 8'd0, 5'd0, 3'd0, 12'h0C7, 3'd2, 32'h0000_7788, 1'b0);
      do_req(6, 1'b0, 8'd1, 5'd0, 3'd0, 12'h0C0, 3'd4, 0, 1'b0);
    end
    lat = 1;
    // R3: rejected targets
    do_req(3, 1'b0, 8'd2, 5'd0, 3'd0, 12'h000, 3'd4, 0, 1'b0);
    do_req(3, 1'b1, 8'd1, 5'd3, 3'd0, 12'h004, 3'd4, 32'h55, 1'b0);
    do_req(3, 1'b0, 8'd0, 5'd0, 3'd1, 12'h008, 3'd1, 0, 1'b0);
    // R4: bad sizes and precedence
    do_req(4, 1'b0, 8'd0, 5'd0, 3'd0, 12'h010, 3'd3, 0, 1'b0);
    do_req(4, 1'b1, 8'd1, 5'd0, 3'd0, 12'h010, 3'd0, 32'h9, 1'b0);
    do_req(4, 1'b0, 8'd5, 5'd0, 3'd0, 12'h010, 3'd3, 0, 1'b0);
    // R8: request while busy is ignored (reject, read and rmw paths)
    do_req(8, 1'b0, 8'd2, 5'd0, 3'd0, 12'h000, 3'd4, 0, 1'b1);
    do_req(8, 1'b0, 8'd0, 5'd0, 3'd0, 12'h020, 3'd4, 0, 1'b1);
    do_req(8, 1'b1, 8'd0, 5'd0, 3'd0, 12'h031, 3'd1, 32'h3C, 1'b1);
    do_req(8, 1'b0, 8'd0, 5'd0, 3'd0, 12'h040, 3'd4, 0, 1'b0);
    // R10: nothing left pending
    chk(10, "pending responses", exp_rsp.size(), 0);
    chk(9,  "pending accesses",  exp_acc.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule